// File: doc/BRIEF.md
# Five-Rail Power Sequencer

This block brings up and shuts down a peripheral that needs five supply rails, switched in a fixed order. Each rail has a regulator enable output and a power-good input. A power-on request holds the device reset low and turns the rails on from rail 0 to rail 4. It turns on one rail at a time, and each rail must report good before the next one is enabled. Once all five rails are good, the block raises an aggregate power-good output. After a fixed delay it releases the device reset.

A power-off request does the reverse. It asserts reset first, waits a fixed hold time, and drops the aggregate power-good. It then turns the rails off from rail 4 down to rail 0. Each rail has its own enable polarity and its own power-good timeout, and every delay is given in microseconds and scaled by the clock frequency parameter. A rail that times out while powering on sends the block into the full power-off path, so the device never leaves reset. A rail that refuses to drop while powering off is flagged, and the walk carries on past it. A per-rail fail mask records each fault until the next accepted request.

Requests are single-cycle pulses. All pins are plain control and status levels; there is no data stream and no handshake.

Top module: `rail_power_seq`

## Requirements
- R1: After reset every rail is logically off, so the enable pins equal EN_ACTIVE_LOW (default 5'b00100, bit i is rail i). In the same state dev_rst_n_o and all_pg_o are low, busy_o and powered_on_o are low, and fail_mask_o is zero.
- R2: Power-on enables rails in order 0 to 4, and rail i+1 is enabled only after rail i's power-good has been seen high. The set of logically enabled rails is always a run starting at rail 0.
- R3: Each enable pin equals the rail's logical enable XOR its EN_ACTIVE_LOW bit. With the default polarity, the pins read 5'b00100 when all rails are off and 5'b11011 when all are on.
- R4: Rail i times out if its synchronized power-good does not match the target within its own limit. The limit is RAIL_TMO_US field i (bits [24i+23:24i]) in microseconds, converted at CLK_HZ.
- R5: all_pg_o rises once rail 4 reports good, and dev_rst_n_o rises ON_DLY_US later. dev_rst_n_o is never high while all_pg_o is low, and it stays low for the whole rail ramp.
- R6: A power-on timeout on rail i sets fail_mask_o bit i and runs the full power-off sequence. In this case all_pg_o is never asserted, reset stays low, and the block ends idle with powered_on_o low.
- R7: Power-off drives dev_rst_n_o low first and drops all_pg_o OFF_DLY_US later. It then disables the rails from rail 4 down to rail 0, and no rail is re-enabled during the walk.
- R8: During power-off, a rail whose power-good stays high past its limit gets its fail_mask_o bit set, and the remaining lower rails are still turned off.
- R9: on_req is ignored while powered on or busy, and off_req is ignored unless powered on. An ignored request leaves busy_o, powered_on_o, the pins and fail_mask_o unchanged.
- R10: fail_mask_o is cleared when a request is accepted and holds its value while the block is not busy.
- R11: busy_o is high from the cycle after an accepted request until the sequence ends. powered_on_o is high only once the block is fully up with reset released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| on_req | input | 1 | Power-on request pulse |
| off_req | input | 1 | Power-off request pulse |
| pg_in | input | NUM_RAILS | Raw regulator power-good inputs, bit i is rail i |
| rail_en_o | output | NUM_RAILS | Regulator enable pins at physical polarity |
| all_pg_o | output | 1 | Aggregate power-good to the device |
| dev_rst_n_o | output | 1 | Device reset, low = held in reset |
| busy_o | output | 1 | A sequence is running |
| powered_on_o | output | 1 | Device fully powered and out of reset |
| fail_mask_o | output | NUM_RAILS | Per-rail timeout flags of the last sequence |

## Verification
The hardest situations to reach from the ports are fault paths inside a sequence. One is a rail that never comes up partway through the ramp, which must turn into a clean unwind. The other is a rail whose power-good stays high during shutdown while the rails below it must still be switched off. The bench drives these with a behavioural regulator model that has per-rail "dead" and "stuck-high" masks. It shortens every limit through the frequency and microsecond parameters so that timeouts elapse in a few hundred cycles. It also fires requests in the middle of running sequences to confirm they are ignored.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ON_WAIT,
    ST_ON_DLY,
    ST_ON,
    ST_OFF_HOLD,
    ST_OFF_WAIT
  } seq_state_e;

  function automatic longint us_to_cycles(longint us, longint hz);
    return (us * hz) / 64'd1000000;
  endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_in[g];
        stab_q <= meta_q;
      end
    end
    assign q_out[g] = stab_q;
  end
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero = (cnt_q == '0);

  // R4
  timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/pwrseq_rail_io.sv
module pwrseq_rail_io #(
  parameter int                   NUM_RAILS     = 5,
  parameter int                   IDX_W         = 3,
  parameter logic [NUM_RAILS-1:0] EN_ACTIVE_LOW = 5'b00100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_set,
  input  logic                 en_clr,
  input  logic [IDX_W-1:0]     en_idx,
  output logic [NUM_RAILS-1:0] en_log,
  output logic [NUM_RAILS-1:0] en_pin
);
  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    logic on_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 on_q <= 1'b0;
      else if (en_set && en_idx == IDX_W'(g))     on_q <= 1'b1;
      else if (en_clr && en_idx == IDX_W'(g))     on_q <= 1'b0;
    end
    assign en_log[g] = on_q;
    if (EN_ACTIVE_LOW[g]) begin : g_low
      assign en_pin[g] = ~on_q;
    end else begin : g_high
      assign en_pin[g] = on_q;
    end
  end

  // R2
  en_run_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_log & NUM_RAILS'(en_log + 1'b1)) == '0));

  // R2
  set_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_set && en_clr));
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int NUM_RAILS = 5,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 21
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       on_req,
  input  logic                       off_req,
  input  logic [NUM_RAILS-1:0]       pg_s,
  input  logic [NUM_RAILS-1:0]       en_log,
  input  logic [NUM_RAILS*CNT_W-1:0] tmo_cyc,
  input  logic [CNT_W-1:0]           on_cyc,
  input  logic [CNT_W-1:0]           off_cyc,
  input  logic                       tmr_zero,
  output logic                       tmr_load,
  output logic [CNT_W-1:0]           tmr_val,
  output logic                       en_set,
  output logic                       en_clr,
  output logic [IDX_W-1:0]           en_idx,
  output logic                       all_pg,
  output logic                       dev_rst_n,
  output logic                       busy,
  output logic                       powered_on,
  output logic [NUM_RAILS-1:0]       fail_mask
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_RAILS - 1);

  seq_state_e             state_q, state_d;
  logic [IDX_W-1:0]       idx_q, idx_d;
  logic                   allpg_q, allpg_d;
  logic                   rstn_q, rstn_d;
  logic [NUM_RAILS-1:0]   mask_q, mask_d;

  function automatic logic [CNT_W-1:0] tmo_of(logic [IDX_W-1:0] i);
    return tmo_cyc[int'(i)*CNT_W +: CNT_W] - CNT_W'(1);
  endfunction

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    allpg_d  = allpg_q;
    rstn_d   = rstn_q;
    mask_d   = mask_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    en_set   = 1'b0;
    en_clr   = 1'b0;
    en_idx   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (on_req) begin
          state_d  = ST_ON_WAIT;
          idx_d    = '0;
          rstn_d   = 1'b0;
          mask_d   = '0;
          en_set   = 1'b1;
          en_idx   = '0;
          tmr_load = 1'b1;
          tmr_val  = tmo_of('0);
        end
      end
      ST_ON_WAIT: begin
        if (pg_s[idx_q]) begin
          if (idx_q == LAST) begin
            allpg_d  = 1'b1;
            state_d  = ST_ON_DLY;
            tmr_load = 1'b1;
            tmr_val  = on_cyc - CNT_W'(1);
          end else begin
            idx_d    = idx_q + 1'b1;
            en_set   = 1'b1;
            en_idx   = idx_q + 1'b1;
            tmr_load = 1'b1;
            tmr_val  = tmo_of(idx_q + 1'b1);
          end
        end else if (tmr_zero) begin
          mask_d[idx_q] = 1'b1;
          state_d  = ST_OFF_HOLD;
          tmr_load = 1'b1;
          tmr_val  = off_cyc - CNT_W'(1);
        end
      end
      ST_ON_DLY: begin
        if (tmr_zero) begin
          rstn_d  = 1'b1;
          state_d = ST_ON;
        end
      end
      ST_ON: begin
        if (off_req) begin
          rstn_d   = 1'b0;
          mask_d   = '0;
          state_d  = ST_OFF_HOLD;
          tmr_load = 1'b1;
          tmr_val  = off_cyc - CNT_W'(1);
        end
      end
      ST_OFF_HOLD: begin
        if (tmr_zero) begin
          allpg_d  = 1'b0;
          idx_d    = LAST;
          en_clr   = 1'b1;
          en_idx   = LAST;
          tmr_load = 1'b1;
          tmr_val  = tmo_of(LAST);
          state_d  = ST_OFF_WAIT;
        end
      end
      ST_OFF_WAIT: begin
        if (!pg_s[idx_q] || tmr_zero) begin
          if (pg_s[idx_q]) mask_d[idx_q] = 1'b1;
          if (idx_q == '0) begin
            state_d = ST_IDLE;
          end else begin
            idx_d    = idx_q - 1'b1;
            en_clr   = 1'b1;
            en_idx   = idx_q - 1'b1;
            tmr_load = 1'b1;
            tmr_val  = tmo_of(idx_q - 1'b1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      allpg_q <= 1'b0;
      rstn_q  <= 1'b0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      allpg_q <= allpg_d;
      rstn_q  <= rstn_d;
      mask_q  <= mask_d;
    end
  end

  assign all_pg     = allpg_q;
  assign dev_rst_n  = rstn_q;
  assign fail_mask  = mask_q;
  assign powered_on = (state_q == ST_ON);
  assign busy       = (state_q != ST_IDLE) && (state_q != ST_ON);

  // R5
  rst_needs_allpg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_n |-> all_pg);

  // R11
  powered_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    powered_on |-> ((&en_log) && all_pg && dev_rst_n));

  // R10
  fail_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(fail_mask));

  // R7
  off_no_reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF_HOLD || state_q == ST_OFF_WAIT) |=>
      ((en_log & ~$past(en_log)) == '0));

  // R6
  fail_blocks_allpg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ON_WAIT && !pg_s[idx_q] && tmr_zero) |=> !all_pg && !dev_rst_n);
endmodule

// File: rtl/rail_power_seq.sv
module rail_power_seq #(
  parameter int                          NUM_RAILS     = 5,
  parameter longint                      CLK_HZ        = 100000000,
  parameter int                          TMO_W         = 24,
  parameter logic [NUM_RAILS*TMO_W-1:0]  RAIL_TMO_US   = {NUM_RAILS{24'd20000}},
  parameter logic [NUM_RAILS-1:0]        EN_ACTIVE_LOW = 5'b00100,
  parameter longint                      ON_DLY_US     = 1000,
  parameter longint                      OFF_DLY_US    = 5000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 on_req,
  input  logic                 off_req,
  input  logic [NUM_RAILS-1:0] pg_in,
  output logic [NUM_RAILS-1:0] rail_en_o,
  output logic                 all_pg_o,
  output logic                 dev_rst_n_o,
  output logic                 busy_o,
  output logic                 powered_on_o,
  output logic [NUM_RAILS-1:0] fail_mask_o
);
  function automatic longint at_least_one(longint c);
    return (c < 1) ? 64'd1 : c;
  endfunction

  function automatic longint rail_cyc(int i);
    return at_least_one(pwrseq_pkg::us_to_cycles(
      longint'(RAIL_TMO_US[i*TMO_W +: TMO_W]), CLK_HZ));
  endfunction

  localparam longint ON_CYC  = at_least_one(pwrseq_pkg::us_to_cycles(ON_DLY_US, CLK_HZ));
  localparam longint OFF_CYC = at_least_one(pwrseq_pkg::us_to_cycles(OFF_DLY_US, CLK_HZ));

  function automatic longint max_cyc();
    longint m = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
    for (int i = 0; i < NUM_RAILS; i++) begin
      if (rail_cyc(i) > m) m = rail_cyc(i);
    end
    return m;
  endfunction

  localparam int IDX_W = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1;
  localparam int CNT_W = $clog2(max_cyc() + 1);

  logic [NUM_RAILS*CNT_W-1:0] tmo_cyc;
  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_tmo
    assign tmo_cyc[g*CNT_W +: CNT_W] = CNT_W'(rail_cyc(g));
  end

  logic [NUM_RAILS-1:0] pg_s, en_log;
  logic                 tmr_load, tmr_zero, en_set, en_clr;
  logic [CNT_W-1:0]     tmr_val;
  logic [IDX_W-1:0]     en_idx;

  pwrseq_sync #(.WIDTH(NUM_RAILS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pg_in), .q_out(pg_s)
  );

  pwrseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  pwrseq_rail_io #(
    .NUM_RAILS(NUM_RAILS), .IDX_W(IDX_W), .EN_ACTIVE_LOW(EN_ACTIVE_LOW)
  ) u_rails (
    .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr), .en_idx(en_idx),
    .en_log(en_log), .en_pin(rail_en_o)
  );

  pwrseq_fsm #(
    .NUM_RAILS(NUM_RAILS), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
    .pg_s(pg_s), .en_log(en_log), .tmo_cyc(tmo_cyc),
    .on_cyc(CNT_W'(ON_CYC)), .off_cyc(CNT_W'(OFF_CYC)), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .en_set(en_set), .en_clr(en_clr),
    .en_idx(en_idx), .all_pg(all_pg_o), .dev_rst_n(dev_rst_n_o), .busy(busy_o),
    .powered_on(powered_on_o), .fail_mask(fail_mask_o)
  );
endmodule

// File: tb/tb_rail_power_seq.sv
module tb_rail_power_seq;
  localparam logic [4:0] POL   = 5'b00100;
  localparam int         ONC   = 40;
  localparam int         OFFC  = 100;
  localparam int         LIMIT = 100000;

  typedef struct packed {
    logic       is_off;
    logic [4:0] dead;
    logic [4:0] stuck;
    logic [4:0] exp_mask;
    logic       exp_on;
    logic       exp_ign;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 5'h00, 5'h00, 5'h00, 1'b1, 1'b0},
    '{1'b0, 5'h00, 5'h00, 5'h00, 1'b1, 1'b1},
    '{1'b1, 5'h00, 5'h00, 5'h00, 1'b0, 1'b0},
    '{1'b1, 5'h00, 5'h00, 5'h00, 1'b0, 1'b1},
    '{1'b0, 5'h08, 5'h00, 5'h08, 1'b0, 1'b0},
    '{1'b0, 5'h01, 5'h00, 5'h01, 1'b0, 1'b0},
    '{1'b0, 5'h00, 5'h00, 5'h00, 1'b1, 1'b0},
    '{1'b1, 5'h00, 5'h04, 5'h04, 1'b0, 1'b0},
    '{1'b0, 5'h10, 5'h00, 5'h10, 1'b0, 1'b0},
    '{1'b0, 5'h00, 5'h00, 5'h00, 1'b1, 1'b0},
    '{1'b1, 5'h00, 5'h11, 5'h11, 1'b0, 1'b0},
    '{1'b0, 5'h00, 5'h00, 5'h00, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_req = 1'b0, off_req = 1'b0;
  logic [4:0] pg_in, rail_en_o, fail_mask_o;
  logic all_pg_o, dev_rst_n_o, busy_o, powered_on_o;
  logic [4:0] dead = '0, stuck = '0;
  logic [4:0] d0 = '0, d1 = '0, d2 = '0, d3 = '0;
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0, saw_allpg = 0;

  always #4 clk = ~clk;

  rail_power_seq #(
    .CLK_HZ(1000000),
    .RAIL_TMO_US({24'd400, 24'd350, 24'd300, 24'd250, 24'd200}),
    .ON_DLY_US(ONC), .OFF_DLY_US(OFFC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req), .pg_in(pg_in),
    .rail_en_o(rail_en_o), .all_pg_o(all_pg_o), .dev_rst_n_o(dev_rst_n_o),
    .busy_o(busy_o), .powered_on_o(powered_on_o), .fail_mask_o(fail_mask_o)
  );

  wire [4:0] en_l = rail_en_o ^ POL;

  // regulator model: power-good follows logical enable after four cycles
  always @(posedge clk) begin
    d0 <= en_l; d1 <= d0; d2 <= d1; d3 <= d2;
    cyc <= cyc + 1;
  end
  assign pg_in = (d3 | stuck) & ~dead;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  logic [4:0] prev_en = '0;
  logic prev_allpg = 0, prev_rstn = 0;
  int t_allpg = 0, t_rstfall = 0;

  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < 5; i++) begin
      if (en_l[i] && !prev_en[i]) begin
        if (i > 0) begin
          chk(pg_in[i-1] && en_l[i-1], "R2", "rail enabled before predecessor good", i, i - 1);
        end
        chk(!dev_rst_n_o, "R5", "reset released during ramp", 1, 0);
      end
      if (!en_l[i] && prev_en[i]) begin
        chk(!all_pg_o && !dev_rst_n_o && ((en_l >> (i + 1)) == 0), "R7",
            "rail disabled out of order", int'(en_l), 0);
      end
    end
    if (all_pg_o && !prev_allpg) begin
      t_allpg = cyc;
      saw_allpg = 1;
    end
    if (dev_rst_n_o && !prev_rstn)
      chk((cyc - t_allpg) >= ONC && (cyc - t_allpg) <= ONC + 1, "R5",
          "all_pg to reset release gap", cyc - t_allpg, ONC);
    if (!dev_rst_n_o && prev_rstn) t_rstfall = cyc;
    if (!all_pg_o && prev_allpg)
      chk((cyc - t_rstfall) >= OFFC && (cyc - t_rstfall) <= OFFC + 1, "R7",
          "reset to all_pg drop gap", cyc - t_rstfall, OFFC);
    prev_en = en_l;
    prev_allpg = all_pg_o;
    prev_rstn = dev_rst_n_o;
  end

  task automatic pulse(bit off);
    @(negedge clk);
    if (off) off_req = 1; else on_req = 1;
    @(negedge clk);
    on_req = 0; off_req = 0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 5000 && busy_o; n++) @(negedge clk);
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1;
    $finish;
  endtask

  always @(posedge clk) if (cyc > LIMIT && !finished) begin
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rail_en_o == POL, "R1", "pins in reset", rail_en_o, POL);
    chk(!all_pg_o && !dev_rst_n_o, "R1", "all_pg/rst low", {all_pg_o, dev_rst_n_o}, 0);
    chk(!busy_o && !powered_on_o && fail_mask_o == 0, "R1", "status idle",
        {busy_o, powered_on_o, fail_mask_o}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 12; v++) begin
      logic [4:0] pins_before;
      logic [4:0] mask_before;
      dead = VECS[v].dead;
      stuck = VECS[v].stuck;
      saw_allpg = 0;
      pins_before = rail_en_o;
      mask_before = fail_mask_o;
      pulse(VECS[v].is_off);
      if (VECS[v].exp_ign) begin
        repeat (4) begin
          // R9 ignored request changes nothing
          chk(!busy_o && rail_en_o == pins_before && fail_mask_o == mask_before, "R9",
              "ignored request had effect", {busy_o, rail_en_o}, {1'b0, pins_before});
          @(negedge clk);
        end
      end else begin
        // R11 busy follows accepted request
        chk(busy_o && !powered_on_o, "R11", "busy after accept", busy_o, 1);
        wait_idle();
      end
      // R6 R8 R10 fail mask result
      chk(fail_mask_o == VECS[v].exp_mask, "R10", "fail mask", fail_mask_o, VECS[v].exp_mask);
      chk(powered_on_o == VECS[v].exp_on && !busy_o, "R11", "powered_on",
          powered_on_o, VECS[v].exp_on);
      chk(all_pg_o == VECS[v].exp_on && dev_rst_n_o == VECS[v].exp_on, "R5",
          "all_pg/rst end state", {all_pg_o, dev_rst_n_o}, {2{VECS[v].exp_on}});
      // R3 physical pin polarity
      chk(rail_en_o == (VECS[v].exp_on ? ~POL : POL), "R3", "pins end state",
          rail_en_o, VECS[v].exp_on ? ~POL : POL);
      if (VECS[v].dead != 0)
        chk(!saw_allpg, "R6", "all_pg asserted on failed power-on", 1, 0);
      dead = '0;
      stuck = '0;
      repeat (10) @(negedge clk);
    end

    // R9 off_req during ramp is ignored; currently powered on from last vector
    pulse(1);
    wait_idle();
    pulse(0);
    repeat (3) @(negedge clk);
    off_req = 1; @(negedge clk); off_req = 0;
    wait_idle();
    chk(powered_on_o && fail_mask_o == 0, "R9", "off_req during ramp", powered_on_o, 1);
    // R9 on_req during power-off is ignored
    pulse(1);
    repeat (3) @(negedge clk);
    on_req = 1; @(negedge clk); on_req = 0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(!powered_on_o && !busy_o && rail_en_o == POL, "R9", "on_req during power-off",
        rail_en_o, POL);

    // R4 per-rail timeout length on rail 1 (250 cycles)
    begin
      int t_en = 0;
      dead = 5'b00010;
      pulse(0);
      for (int n = 0; n < 2000 && !en_l[1]; n++) @(negedge clk);
      t_en = cyc;
      for (int n = 0; n < 2000 && !fail_mask_o[1]; n++) @(negedge clk);
      chk((cyc - t_en) >= 249 && (cyc - t_en) <= 252, "R4", "rail 1 timeout length",
          cyc - t_en, 250);
      wait_idle();
      chk(fail_mask_o == 5'b00010 && !powered_on_o, "R6", "unwind after rail 1 timeout",
          fail_mask_o, 2);
      dead = '0;
    end

    repeat (5) @(negedge clk);
    summary();
  end
endmodule